// File: doc/BRIEF.md
# Addressable Bit Latch Array

This block holds eight single-bit storage cells and writes one serial data bit into the cell picked by a three-bit address. Each stored bit always drives its own parallel output, whatever the control inputs are doing. Two control inputs set the behaviour for the cycle:

- **Write block.** Active high. While it is low, the selected cell takes the data bit.
- **Clear.** Active high. It zeroes either the cells that are not selected or every cell, depending on the write-block state.

With writing enabled and clear raised, the block acts as a one-hot demultiplexer. The selected cell carries the data bit and all the other cells are zero.

All inputs are sampled on the rising edge of the system clock, so level-sensitive behaviour is reproduced cycle by cycle. While writing stays enabled, the selected cell follows the data input on every edge. Moving the address while writing is enabled would spill data into the wrong cells. A guard therefore raises a one-cycle error flag whenever two consecutive write-enabled samples carry different addresses. A synchronous initialisation input clears every cell and the flag, separately from the functional clear.

Top module: `bitlatch_array`

## Requirements
- R1: With `rst` high at a rising edge, every bit of `q_o` and `addr_err_o` is 0 after that edge, whatever the other inputs are.
- R2: With `wr_block_i`=0 and `clear_i`=0 at an edge, bit `addr_i` of `q_o` takes `din_i` after the edge and the other seven bits keep their values.
- R3: With `wr_block_i`=0 and `clear_i`=1 at an edge, bit `addr_i` of `q_o` takes `din_i` after the edge and the other seven bits become 0.
- R4: With `wr_block_i`=1 and `clear_i`=0 at an edge, `q_o` is unchanged after the edge, and `din_i` and `addr_i` have no effect.
- R5: With `wr_block_i`=1 and `clear_i`=1 at an edge, `q_o` is 0 after the edge.
- R6: The address is plain binary with `addr_i[2]` as the most significant bit, so the value k selects `q_o[k]`.
- R7: `addr_err_o` is 1 for the cycle after an edge at which `wr_block_i`=0, the previous edge also had `wr_block_i`=0 (and was not under `rst`), and `addr_i` differs from its value at that previous edge.
- R8: `addr_err_o` stays 0 when the address changes across an edge pair in which either edge had `wr_block_i`=1, and when the address is steady.
- R9: While writing stays enabled on one address, the selected bit tracks `din_i` on every edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous initialisation, active high |
| wr_block_i | input | 1 | Write block, active high |
| clear_i | input | 1 | Functional clear, active high |
| addr_i | input | 3 | Cell select, binary |
| din_i | input | 1 | Serial data bit |
| q_o | output | 8 | Stored bits, parallel |
| addr_err_o | output | 1 | Address moved while writing, one-cycle pulse |

## Verification
A data write and a clear of the other cells can land on the same edge when write block is low and clear is high. That edge must leave exactly the selected cell equal to the data bit. The bench provokes it directly for every address with both data values, starting from all-ones contents so that any missed clear shows up. Random mixes also drive address moves together with writes, so the error flag and a real write occur in the same cycle. Each such cycle is judged against a bench model, which must match both the stored pattern and the flag.

// File: rtl/bitlatch_pkg.sv
package bitlatch_pkg;
    parameter int NUM_CELLS = 8;
    localparam int ADDR_W = $clog2(NUM_CELLS);

    typedef logic [NUM_CELLS-1:0] cells_t;
    typedef logic [ADDR_W-1:0]    addr_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,   // store addressed, hold others
        OP_DEMUX = 2'b01,   // store addressed, zero others
        OP_HOLD  = 2'b10,   // keep everything
        OP_WIPE  = 2'b11    // zero everything
    } op_t;

    function automatic op_t op_from_ctrl(input logic wr_block, input logic clear);
        return op_t'({wr_block, clear});
    endfunction

    function automatic cells_t next_cells(input op_t op, input cells_t cur,
                                          input cells_t sel, input logic d);
        cells_t dv;
        dv = sel & {NUM_CELLS{d}};
        case (op)
            OP_WRITE: return (cur & ~sel) | dv;
            OP_DEMUX: return dv;
            OP_HOLD:  return cur;
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/bl_decoder.sv
module bl_decoder
    import bitlatch_pkg::*;
(
    input  addr_t  addr,
    output cells_t sel
);
    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_sel
        assign sel[k] = (addr == ADDR_W'(k));
    end

    always_comb begin
        a_r6_sel_onehot: assert ($countones(sel) == 1);
    end
endmodule

// File: rtl/bl_mode_ctrl.sv
module bl_mode_ctrl
    import bitlatch_pkg::*;
(
    input  logic wr_block,
    input  logic clear,
    output op_t  op
);
    assign op = op_from_ctrl(wr_block, clear);
endmodule

// File: rtl/bl_addr_guard.sv
module bl_addr_guard
    import bitlatch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_block,
    input  addr_t addr,
    output logic  err
);
    addr_t prev_addr;
    logic  prev_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr <= '0;
            prev_en   <= 1'b0;
            err       <= 1'b0;
        end else begin
            prev_addr <= addr;
            prev_en   <= ~wr_block;
            err       <= ~wr_block & prev_en & (addr != prev_addr);
        end
    end

    a_r7_err_cause: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(wr_block) == 1'b0));
    a_r8_no_err_when_blocked: assert property (@(posedge clk) disable iff (rst)
        wr_block |=> !err);
endmodule

// File: rtl/bitlatch_array.sv
module bitlatch_array
    import bitlatch_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_block_i,
    input  logic                 clear_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 din_i,
    output logic [NUM_CELLS-1:0] q_o,
    output logic                 addr_err_o
);
    cells_t sel;
    op_t    op;
    cells_t cells_q;

    bl_decoder u_dec (
        .addr (addr_i),
        .sel  (sel)
    );

    bl_mode_ctrl u_mode (
        .wr_block (wr_block_i),
        .clear    (clear_i),
        .op       (op)
    );

    bl_addr_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_block (wr_block_i),
        .addr     (addr_i),
        .err      (addr_err_o)
    );

    always_ff @(posedge clk) begin
        if (rst) cells_q <= '0;
        else     cells_q <= next_cells(op, cells_q, sel, din_i);
    end

    assign q_o = cells_q;

    a_r1_init_clears: assert property (@(posedge clk)
        rst |=> (q_o == '0));
    a_r2_others_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_block_i && !clear_i) |=> (((q_o ^ $past(q_o)) & ~$past(sel)) == '0));
    a_r3_demux_single: assert property (@(posedge clk) disable iff (rst)
        (!wr_block_i && clear_i) |=> ($countones(q_o) <= 1));
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_block_i && !clear_i) |=> $stable(q_o));
    a_r5_wipe_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_block_i && clear_i) |=> (q_o == '0));
endmodule

// File: tb/bitlatch_array_tb.sv
module bitlatch_array_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_block_i = 1'b1;
    logic       clear_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic       din_i = 1'b0;
    logic [7:0] q_o;
    logic       addr_err_o;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_q = '0;
    logic [2:0] m_prev_addr = '0;
    logic       m_prev_en = 1'b0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    bitlatch_array u_dut (
        .clk(clk), .rst(rst), .wr_block_i(wr_block_i), .clear_i(clear_i),
        .addr_i(addr_i), .din_i(din_i), .q_o(q_o), .addr_err_o(addr_err_o)
    );

    function automatic string tag_of(input logic r, input logic wb, input logic cl);
        if (r) return "R1";
        case ({wb, cl})
            2'b00: return "R2/R6/R9";
            2'b01: return "R3/R6";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic model_step();
        logic [7:0] s;
        s = 8'b1 << addr_i;
        if (rst) begin
            m_q = '0; m_err = 1'b0; m_prev_en = 1'b0; m_prev_addr = '0;
        end else begin
            m_err = !wr_block_i && m_prev_en && (addr_i != m_prev_addr);
            case ({wr_block_i, clear_i})
                2'b00: m_q = (m_q & ~s) | (din_i ? s : 8'h00);
                2'b01: m_q = din_i ? s : 8'h00;
                2'b10: m_q = m_q;
                default: m_q = '0;
            endcase
            m_prev_en = !wr_block_i;
            m_prev_addr = addr_i;
        end
    endtask

    task automatic step(input logic r, input logic wb, input logic cl,
                        input logic [2:0] a, input logic d);
        string t;
        @(negedge clk);
        rst = r; wr_block_i = wb; clear_i = cl; addr_i = a; din_i = d;
        t = tag_of(r, wb, cl);
        @(posedge clk);
        model_step();
        #1;
        checks++;
        if (q_o !== m_q) begin
            fails++;
            $display("FAIL %s q_o actual=%b expected=%b", t, q_o, m_q);
        end
        checks++;
        if (addr_err_o !== m_err) begin
            fails++;
            $display("FAIL %s addr_err_o actual=%b expected=%b",
                     m_err ? "R7" : "R8", addr_err_o, m_err);
        end
    endtask

    task automatic fill_ones();
        for (int k = 0; k < 8; k++) step(0, 0, 0, 3'(k), 1'b1);
        step(0, 1, 0, 3'd7, 1'b0);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd12345);
        // R1 initial state
        step(1, 1, 0, 3'd0, 1'b0);
        step(1, 0, 1, 3'd5, 1'b1);
        // R2/R6: each address written alone from zero, then hold
        for (int k = 0; k < 8; k++) begin
            step(1, 1, 0, 3'd0, 1'b0);
            step(0, 1, 0, 3'(k), 1'b0);
            step(0, 0, 0, 3'(k), 1'b1);
            step(0, 1, 0, 3'(k), 1'b0);
        end
        // R4: hold with toggling data and address over several cycles
        fill_ones();
        step(0, 0, 0, 3'd2, 1'b0);
        for (int k = 0; k < 8; k++) step(0, 1, 0, 3'(7 - k), k[0]);
        // R3: demux from all ones for every address and both data values
        for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 2; d++) begin
                fill_ones();
                step(0, 0, 1, 3'(k), d[0]);
            end
        end
        // R5: wipe from all ones, any address/data
        for (int k = 0; k < 8; k++) begin
            fill_ones();
            step(0, 1, 1, 3'(k), k[1]);
        end
        // R9: transparent follow on one address
        step(0, 1, 0, 3'd4, 1'b0);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 3'd4, k[0]);
        // R7: address move during writing; R8: move while blocked, move on enabling edge
        step(0, 0, 0, 3'd5, 1'b1);
        step(0, 1, 0, 3'd1, 1'b1);
        step(0, 0, 0, 3'd3, 1'b1);
        step(0, 0, 0, 3'd3, 1'b0);
        // R1: init in the middle of writing
        fill_ones();
        step(1, 0, 0, 3'd6, 1'b1);
        step(0, 0, 0, 3'd2, 1'b1);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            step(rv[7:5] == 3'd0, rv[0] & rv[4], rv[1] & rv[3], rv[6:4] ^ rv[2:0], rv[2]);
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule